// File: doc/BRIEF.md
# Video Transfer Output-Enable Controller

This block produces the active-low strobe that serves as both data-transfer and output enable for a video RAM. When the active-low transfer-load request falls, the strobe falls at once through a purely combinational path, with no clock delay. The strobe is therefore already low before the row strobe, which is generated elsewhere, begins the shift-register load cycle. The strobe rises again on the first of two events: the request rising, or the fourth rising clock edge counted from the fall.

Outside a load cycle the strobe acts as an ordinary read output enable and follows the active-low window input. While the request is low, the window input is ignored. After a timeout the strobe stays high until the request has been seen high on a rising edge and then falls again. A one-clock done pulse marks the end of each load access, so that a neighbouring arbiter can lift its lockout of the second port and of refresh.

Top module: `xfer_oe_ctrl`

## Requirements
- R1: When the transfer-load request falls while the controller is armed, the strobe goes low in the same instant, before any clock edge.
- R2: The strobe stays low for at most EDGES rising clock edges (default 4) after the request falls. It goes high right after the EDGES-th edge if the request is still low.
- R3: While the request is low, the window input has no effect on the strobe. The strobe stays low inside the cycle and stays high after a timeout.
- R4: When the request is high, the strobe equals the window input (0 enables the output, 1 disables it). This includes the instant the request rises during a cycle.
- R5: The done output is high for exactly one clock. It is set by the EDGES-th edge on a timeout, or by the first edge after the request rises if at least one edge fell inside the cycle.
- R6: After a timeout, a new cycle needs the request to be sampled high on a rising edge. A high pulse between two edges does not restart the strobe.
- R7: While reset is active (rst_n = 0) the strobe is high and done is low. The edge count is cleared, so a cycle that starts after reset gets the full EDGES edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; rising edges time the strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_n | input | 1 | Active-low transfer-load request |
| win_n | input | 1 | Active-low window / read output enable |
| dtoe_n | output | 1 | Active-low transfer / output-enable strobe |
| done | output | 1 | One-clock pulse at the end of a load access |

## Verification
The bench sweeps the release point of the request across every edge count from zero to past the timeout, with both window levels. Inside each cycle it toggles the window, which catches a mux that lets the window through during a load. An off-by-one counter would show up as a strobe that rises one edge early or late. A missing expiry state would let the strobe fall back low while the request stays low. The bench also sends a short high pulse between edges after a timeout, which catches a re-arm that is too eager, and it applies reset in mid-cycle to check that the edge count does not carry over.

// File: rtl/xoe_pkg.sv
`timescale 1ns/1ps
package xoe_pkg;
  // True when the current count is the last edge of the allowed window.
  function automatic logic is_final_edge(input int unsigned cnt, input int unsigned limit);
    return cnt == limit - 1;
  endfunction
endpackage

// File: rtl/xoe_edge_counter.sv
`timescale 1ns/1ps
module xoe_edge_counter #(
  parameter int unsigned EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last_edge
);
  localparam int unsigned CW = $clog2(EDGES + 1);
  logic [CW-1:0] cnt_q;

  assign last_edge = run && xoe_pkg::is_final_edge(32'(cnt_q), EDGES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (last_edge)  cnt_q <= '0;
    else                 cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/xoe_cycle_ctrl.sv
`timescale 1ns/1ps
module xoe_cycle_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_n,
  input  logic last_edge,
  output logic armed,
  output logic in_load,
  output logic done
);
  logic busy_q;

  assign in_load = rst_n && !xfer_n && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b1;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (xfer_n)                      armed <= 1'b1;
      else if (in_load && last_edge)   armed <= 1'b0;
      busy_q <= in_load && !last_edge;
      done   <= (in_load && last_edge) || (busy_q && xfer_n);
    end
  end
endmodule

// File: rtl/xoe_strobe_mux.sv
`timescale 1ns/1ps
module xoe_strobe_mux (
  input  logic rst_n,
  input  logic xfer_n,
  input  logic in_load,
  input  logic win_n,
  output logic dtoe_n
);
  always_comb begin
    if (!rst_n)       dtoe_n = 1'b1;
    else if (in_load) dtoe_n = 1'b0;
    else if (xfer_n)  dtoe_n = win_n;
    else              dtoe_n = 1'b1;
  end
endmodule

// File: rtl/xfer_oe_ctrl.sv
`timescale 1ns/1ps
module xfer_oe_ctrl #(
  parameter int unsigned EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_n,
  input  logic win_n,
  output logic dtoe_n,
  output logic done
);
  logic load_run;
  logic load_last;
  logic load_armed;

  xoe_edge_counter #(.EDGES(EDGES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(load_run), .last_edge(load_last)
  );

  xoe_cycle_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .xfer_n(xfer_n), .last_edge(load_last),
    .armed(load_armed), .in_load(load_run), .done(done)
  );

  xoe_strobe_mux u_mux (
    .rst_n(rst_n), .xfer_n(xfer_n), .in_load(load_run), .win_n(win_n),
    .dtoe_n(dtoe_n)
  );
endmodule

// File: rtl/xfer_oe_ctrl_chk.sv
`timescale 1ns/1ps
module xfer_oe_ctrl_chk #(
  parameter int unsigned EDGES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic xfer_n,
  input logic win_n,
  input logic dtoe_n,
  input logic done,
  input logic load_armed
);
  int unsigned low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_run <= 0;
    else if (!dtoe_n && !xfer_n) low_run <= low_run + 1;
    else                        low_run <= 0;
  end

  AST_FALL_NOW:     assert property (@(posedge clk) disable iff (!rst_n) (!xfer_n && load_armed) |-> !dtoe_n); // R1
  AST_MAX_WIDTH:    assert property (@(posedge clk) disable iff (!rst_n) low_run <= EDGES); // R2
  AST_EXPIRED_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (!xfer_n && !load_armed) |-> dtoe_n); // R3
  AST_WINDOW_PASS:  assert property (@(posedge clk) disable iff (!rst_n) xfer_n |-> (dtoe_n == win_n)); // R4
  AST_DONE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5

  always_ff @(posedge clk) begin
    if (rst_n === 1'b0) begin
      AST_RESET_IDLE: assert (dtoe_n && !done); // R7
    end
  end
endmodule

bind xfer_oe_ctrl xfer_oe_ctrl_chk #(.EDGES(EDGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_n(xfer_n), .win_n(win_n),
  .dtoe_n(dtoe_n), .done(done), .load_armed(load_armed)
);

// File: tb/xfer_oe_ctrl_bench.sv
`timescale 1ns/1ps
module xfer_oe_ctrl_bench;
  localparam int unsigned EDGES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_n = 1'b1;
  logic win_n = 1'b1;
  logic dtoe_n;
  logic done;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  xfer_oe_ctrl #(.EDGES(EDGES)) u_xfer_oe_ctrl (
    .clk(clk), .rst_n(rst_n), .xfer_n(xfer_n), .win_n(win_n),
    .dtoe_n(dtoe_n), .done(done)
  );

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Strobe level after e edges of a cycle still held low.
  function automatic logic exp_strobe(input int e);
    return (e >= int'(EDGES)) ? 1'b1 : 1'b0;
  endfunction

  task automatic run_cycle(input int k, input logic w);
    win_n = w;
    xfer_n = 1'b1;
    step();
    xfer_n = 1'b0;
    #0.5;
    check(dtoe_n, 1'b0, "R1");
    for (int e = 1; e <= k; e++) begin
      step();
      check(dtoe_n, exp_strobe(e), "R2");
      check(done, (e == int'(EDGES)) ? 1'b1 : 1'b0, "R5");
      win_n = ~w;
      #0.2;
      check(dtoe_n, exp_strobe(e), "R3");
      win_n = w;
    end
    xfer_n = 1'b1;
    #0.5;
    check(dtoe_n, w, "R4");
    step();
    check(done, (k >= 1 && k < int'(EDGES)) ? 1'b1 : 1'b0, "R5");
    step();
    check(done, 1'b0, "R5");
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1;
    check(dtoe_n, 1'b1, "R7");
    check(done, 1'b0, "R7");
    step(); step();
    rst_n = 1'b1;
    step();
    check(dtoe_n, win_n, "R4");

    for (int k = 0; k <= int'(EDGES) + 2; k++) begin
      run_cycle(k, 1'b0);
      run_cycle(k, 1'b1);
    end

    // R6: timeout, short high pulse between edges does not re-arm
    win_n = 1'b0;
    xfer_n = 1'b0;
    for (int e = 0; e < int'(EDGES); e++) step();
    check(dtoe_n, 1'b1, "R6");
    #0.3 xfer_n = 1'b1;
    #0.3 xfer_n = 1'b0;
    #0.3;
    check(dtoe_n, 1'b1, "R6");
    step();
    check(dtoe_n, 1'b1, "R6");
    xfer_n = 1'b1;
    step();
    xfer_n = 1'b0;
    #0.5;
    check(dtoe_n, 1'b0, "R6");

    // R7: reset mid-cycle forces strobe high and clears the count
    step(); step();
    rst_n = 1'b0;
    #0.5;
    check(dtoe_n, 1'b1, "R7");
    xfer_n = 1'b1;
    step();
    rst_n = 1'b1;
    step();
    xfer_n = 1'b0;
    for (int e = 1; e < int'(EDGES); e++) begin
      step();
      check(dtoe_n, 1'b0, "R7");
    end
    step();
    check(dtoe_n, 1'b1, "R7");
    check(done, 1'b1, "R7");
    xfer_n = 1'b1;
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule